// File: doc/BRIEF.md
# Serial Transceiver Loopback Core

This block is the digital core of a byte-wide serial line transceiver, reduced to a single fast bit clock. On the transmit side a parallel word is captured once every eight bit cycles and shifted onto the serial line output with its most significant bit first. On the receive side the serial line input is shifted into an accumulator, and every eight bit cycles a finished word is presented with a one-cycle strobe. Two divide-by-eight enables take the place of the byte clocks. One belongs to the transmit side and runs from the synthesized clock. The other belongs to the receive side and runs from the recovered clock. The receive divider starts from its own reset phase, so the two word grids differ.

Four control inputs pick how the two halves are wired together. Facility loopback sends the line input back out. Equipment loopback feeds the serialized transmit stream into the receiver. With both set, the block runs split loopback. Loop timing makes the transmit word grid follow the receive divider. A loss-of-signal input, active low, zeroes the line data on its way into the block. Control changes take effect only when a transmit word is loaded, so the serial output never carries part of a word. The receive word boundary runs free, because frame alignment is done by a separate block.

Top module: `serdes_loop_core`

## Requirements
- R1: A word is captured from `tx_word` on the clock edge that follows a cycle in which `tx_load` is high. Starting with the next cycle, `line_tx` carries its bits for eight cycles, bit 7 first and bit 0 last (when facility loopback is off).
- R2: Out of reset the transmit divider gives `tx_load` in the 7th cycle after reset release and every 8 cycles from then on. The receive divider starts at phase RX_PHASE, so that in normal mode `rx_strobe` first rises in cycle 8-RX_PHASE and then recurs every 8 cycles.
- R3: In normal mode, while `rx_strobe` is high, `rx_word` holds the eight line bits presented in the 9th to 2nd cycles before that cycle, with the oldest bit in bit 7.
- R4: In facility loopback, `line_tx` equals the `line_rx` value of the previous cycle, and `rx_word` is still assembled from the line input as in R3.
- R5: In equipment loopback, each `rx_strobe` comes one cycle after a `tx_load`. `rx_word` then equals the word captured at the load before that one, and `line_tx` still carries the serialized words as in R1.
- R6: In split loopback (both loopback inputs high), `line_tx` follows `line_rx` as in R4 and `rx_word` carries the transmit words as in R5. Neither line data nor transmit words reach the other path.
- R7: With loop timing on, each `tx_load` falls in the cycle where the receive divider wraps, so `rx_strobe` is high in the following cycle. With loop timing off and RX_PHASE nonzero, `rx_strobe` is low in the cycle after a `tx_load`.
- R8: While `los_n` is low, the line input is taken as 0. Words assembled from it are zero, and in facility loopback `line_tx` is low.
- R9: While `rst` is high, `tx_load`, `rx_strobe`, `line_tx` and `rx_word` are all 0. After reset, `line_tx` stays low until the first word has been loaded.
- R10: Loopback and loop-timing inputs are sampled only in a `tx_load` cycle. A change in mid-word leaves that word's bits intact. A transmit enable that arrives while a word is still shifting is skipped, and `line_tx` idles low until the next load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_word | input | WORD_W | Parallel transmit word |
| tx_load | output | 1 | High in the cycle before `tx_word` is captured |
| line_rx | input | 1 | Serial line receive bit |
| los_n | input | 1 | Loss of signal, active low |
| fac_loop | input | 1 | Facility loopback request |
| eq_loop | input | 1 | Equipment loopback request |
| loop_time | input | 1 | Loop timing request |
| line_tx | output | 1 | Serial line transmit bit |
| rx_word | output | WORD_W | Parallel receive word |
| rx_strobe | output | 1 | High for one cycle when `rx_word` is new |

## Verification
Two events can fall in the same cycle. One is the capture of the next transmit word. The other is the sampling of a new loopback or loop-timing setting, and when the loop-timing setting changes, so does the source of the transmit enable. The bench raises facility loopback three cycles into a word, checks that the rest of that word still comes out bit for bit, and then checks that the line input is echoed from the very next cycle. It turns on loop timing while a word is in flight and checks that no load lands inside a word and that the gap before the next aligned load stays low. In equipment and split loopback, a load and a receive strobe occur at the same boundary, and the bench checks that the strobe carries the previous transmit word.

// File: rtl/serdes_loop_pkg.sv
package serdes_loop_pkg;

  typedef struct packed {
    logic fac;
    logic eqp;
    logic lpt;
  } loop_mode_t;

  localparam loop_mode_t MODE_IDLE = '{fac: 1'b0, eqp: 1'b0, lpt: 1'b0};

  function automatic int unsigned phase_next(input int unsigned cur, input int unsigned ratio);
    return (cur + 1 >= ratio) ? 0 : cur + 1;
  endfunction

  function automatic int unsigned bits_left_next(input int unsigned cur);
    return (cur == 0) ? 0 : cur - 1;
  endfunction

endpackage

// File: rtl/serdes_byte_div.sv
module serdes_byte_div
  import serdes_loop_pkg::*;
#(
  parameter int unsigned RATIO = 8,
  parameter int unsigned START = 0
) (
  input  logic clk,
  input  logic rst,
  output logic byte_en
);
  localparam int unsigned CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= CW'(START % RATIO);
    else     phase_q <= CW'(phase_next(32'(phase_q), RATIO));
  end

  assign byte_en = (phase_q == LAST);

  assert_div_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    byte_en |=> (phase_q == '0));

  assert_div_gap_R2: assert property (@(posedge clk) disable iff (rst)
    byte_en |=> !byte_en);

endmodule

// File: rtl/serdes_tx_shift.sv
module serdes_tx_shift
  import serdes_loop_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fire,
  input  logic [W-1:0] word,
  output logic         load,
  output logic         bit_q
);
  localparam int unsigned CW = $clog2(W);

  logic [W-1:0]  sreg;
  logic [CW-1:0] left_q;
  logic          idle;

  assign idle = (left_q == '0);
  assign load = fire && idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg   <= '0;
      left_q <= '0;
      bit_q  <= 1'b0;
    end else if (load) begin
      sreg   <= {word[W-2:0], 1'b0};
      left_q <= CW'(W - 1);
      bit_q  <= word[W-1];
    end else if (!idle) begin
      sreg   <= {sreg[W-2:0], 1'b0};
      left_q <= CW'(bits_left_next(32'(left_q)));
      bit_q  <= sreg[W-1];
    end else begin
      bit_q  <= 1'b0;
    end
  end

  assert_idle_low_R9: assert property (@(posedge clk) disable iff (rst)
    (idle && !load) |=> !bit_q);

  assert_no_back_to_back_R10: assert property (@(posedge clk) disable iff (rst)
    load |=> !load);

  assert_first_bit_R1: assert property (@(posedge clk) disable iff (rst)
    load |=> (bit_q == $past(word[W-1])));

endmodule

// File: rtl/serdes_rx_shift.sv
module serdes_rx_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         din,
  input  logic         grab,
  output logic [W-1:0] word_q,
  output logic         strobe_q
);
  logic [W-2:0] acc;
  logic [W-1:0] next_w;

  assign next_w = {acc, din};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      word_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      acc      <= next_w[W-2:0];
      strobe_q <= grab;
      if (grab) word_q <= next_w;
    end
  end

  assert_word_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !grab |=> $stable(word_q));

  assert_last_bit_R3: assert property (@(posedge clk) disable iff (rst)
    grab |=> (word_q[0] == $past(din)));

endmodule

// File: rtl/serdes_loop_core.sv
module serdes_loop_core
  import serdes_loop_pkg::*;
#(
  parameter int unsigned WORD_W   = 8,
  parameter int unsigned RX_PHASE = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_load,
  input  logic              line_rx,
  input  logic              los_n,
  input  logic              fac_loop,
  input  logic              eq_loop,
  input  logic              loop_time,
  output logic              line_tx,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_strobe
);
  logic       syn_en;
  logic       rec_en;
  logic       tx_fire;
  logic       ser_bit;
  logic       des_din;
  logic       des_grab;
  logic       rx_in_q;
  logic       past_ok;
  loop_mode_t mode_q;
  loop_mode_t mode_d;

  serdes_byte_div #(.RATIO(WORD_W), .START(0)) u_syn_div (
    .clk(clk), .rst(rst), .byte_en(syn_en)
  );

  serdes_byte_div #(.RATIO(WORD_W), .START(RX_PHASE)) u_rec_div (
    .clk(clk), .rst(rst), .byte_en(rec_en)
  );

  assign tx_fire = mode_q.lpt ? rec_en : syn_en;

  serdes_tx_shift #(.W(WORD_W)) u_tx (
    .clk(clk), .rst(rst), .fire(tx_fire), .word(tx_word),
    .load(tx_load), .bit_q(ser_bit)
  );

  assign mode_d = '{fac: fac_loop, eqp: eq_loop, lpt: loop_time};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_IDLE;
      rx_in_q <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      if (tx_load) mode_q <= mode_d;
      rx_in_q <= line_rx & los_n;
      past_ok <= 1'b1;
    end
  end

  assign des_din  = mode_q.eqp ? ser_bit : rx_in_q;
  assign des_grab = mode_q.eqp ? tx_fire : rec_en;

  serdes_rx_shift #(.W(WORD_W)) u_rx (
    .clk(clk), .rst(rst), .din(des_din), .grab(des_grab),
    .word_q(rx_word), .strobe_q(rx_strobe)
  );

  assign line_tx = mode_q.fac ? rx_in_q : ser_bit;

  assert_mode_held_R10: assert property (@(posedge clk) disable iff (rst)
    !tx_load |=> $stable(mode_q));

  assert_fac_echo_R4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && mode_q.fac) |-> (line_tx == $past(line_rx & los_n)));

  assert_los_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && mode_q.fac && !$past(los_n)) |-> !line_tx);

  assert_eq_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_q.eqp && tx_load) |=> rx_strobe);

  assert_loop_align_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_q.lpt && tx_load) |-> rec_en);

  assert_reset_quiet_R9: assert property (@(posedge clk)
    rst |=> (!rx_strobe && !line_tx && rx_word == '0));

endmodule

// File: tb/serdes_loop_core_test.sv
module serdes_loop_core_test;
  localparam int W   = 8;
  localparam int RXP = 3;

  localparam logic [15:0] VEC [8] = '{
    16'hA5_3C, 16'h81_FF, 16'h00_01, 16'hFF_80,
    16'h5A_C3, 16'h7E_00, 16'h13_96, 16'hC8_6D
  };

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] tx_word;
  logic         tx_load;
  logic         line_rx;
  logic         los_n;
  logic         fac_loop, eq_loop, loop_time;
  logic         line_tx;
  logic [W-1:0] rx_word;
  logic         rx_strobe;

  always #10 clk = ~clk;

  serdes_loop_core #(.WORD_W(W), .RX_PHASE(RXP)) uut (
    .clk(clk), .rst(rst), .tx_word(tx_word), .tx_load(tx_load),
    .line_rx(line_rx), .los_n(los_n), .fac_loop(fac_loop),
    .eq_loop(eq_loop), .loop_time(loop_time), .line_tx(line_tx),
    .rx_word(rx_word), .rx_strobe(rx_strobe)
  );

  int errs = 0;
  int checks = 0;
  int loads = 0;
  int remaining = 0;
  int gap = 0;
  bit armed, gap_valid, prev_load, los_drive;
  bit mon_tx, mon_fac, mon_rxl, mon_eq, mon_gap, mon_loop, mon_noloop;
  string fac_tag = "R4";
  string eq_tag = "R5";
  string rxl_tag = "R3";
  logic [15:0]  hist;
  logic [W-1:0] cur_w, last_w, prev_w, tx_next;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic tick(input logic nb);
    @(negedge clk);
    if (mon_tx) begin
      if (armed) begin
        if (remaining > 0) begin
          chk(line_tx == cur_w[remaining-1], "R1", int'(line_tx), int'(cur_w[remaining-1]));
          remaining--;
        end else begin
          chk(line_tx == 1'b0, "R10", int'(line_tx), 0);
        end
      end
      if (tx_load) begin
        if (armed) chk(remaining == 0, "R10", remaining, 0);
        cur_w = tx_word;
        remaining = 8;
        armed = 1;
      end
    end
    if (mon_fac) chk(line_tx == hist[0], fac_tag, int'(line_tx), int'(hist[0]));
    if (mon_rxl && rx_strobe) chk(rx_word == hist[8:1], rxl_tag, int'(rx_word), int'(hist[8:1]));
    if (mon_eq && rx_strobe) chk(rx_word == prev_w, eq_tag, int'(rx_word), int'(prev_w));
    if (mon_gap) begin
      gap++;
      if (tx_load) begin
        if (gap_valid) chk(gap == 8, "R2", gap, 8);
        gap = 0;
        gap_valid = 1;
      end
    end
    if (mon_loop && prev_load) chk(rx_strobe == 1'b1, "R7", int'(rx_strobe), 1);
    if (mon_noloop && prev_load) chk(rx_strobe == 1'b0, "R7", int'(rx_strobe), 0);
    if (tx_load) begin
      prev_w = last_w;
      last_w = tx_word;
      loads++;
    end
    if (prev_load) tx_word = tx_next;
    prev_load = tx_load;
    line_rx = nb;
    los_n = los_drive;
    hist = {hist[14:0], nb & los_drive};
  endtask

  task automatic rnd_tick();
    tick(1'($urandom % 2));
  endtask

  task automatic all_off();
    mon_tx = 0; mon_fac = 0; mon_rxl = 0; mon_eq = 0;
    mon_gap = 0; mon_loop = 0; mon_noloop = 0;
  endtask

  task automatic set_mode(input bit f, input bit e, input bit l);
    int n0;
    all_off();
    fac_loop = f; eq_loop = e; loop_time = l;
    n0 = loads;
    while (loads < n0 + 3) rnd_tick();
    armed = 0;
    gap_valid = 0;
    gap = 0;
  endtask

  task automatic walk_table();
    for (int i = 0; i < 8; i++) begin
      tx_next = VEC[i][15:8];
      for (int b = 7; b >= 0; b--) tick(VEC[i][b]);
    end
  endtask

  initial begin
    #(20 * 200000);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    int n0;
    all_off();
    rst = 1'b1; tx_word = 8'hC6; tx_next = 8'hC6; line_rx = 1'b0; los_n = 1'b1;
    los_drive = 1'b1; fac_loop = 0; eq_loop = 0; loop_time = 0; hist = '0;
    last_w = '0; prev_w = '0; cur_w = '0;
    repeat (3) begin
      @(negedge clk);
      chk(!tx_load && !rx_strobe && !line_tx && rx_word == '0, "R9",
          int'({tx_load, rx_strobe, line_tx}), 0);
    end
    rst = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k <= 7) chk(line_tx == 1'b0, "R9", int'(line_tx), 0);
      chk(tx_load == (k == 7), "R2", int'(tx_load), int'(k == 7));
      chk(rx_strobe == (k == 8 - RXP), "R2", int'(rx_strobe), int'(k == 8 - RXP));
      if (k == 8) chk(line_tx == tx_word[7], "R1", int'(line_tx), int'(tx_word[7]));
      prev_load = tx_load;
    end

    set_mode(0, 0, 0);
    mon_tx = 1; mon_rxl = 1; mon_gap = 1; mon_noloop = 1; rxl_tag = "R3";
    walk_table();

    n0 = loads;
    while (loads == n0) rnd_tick();
    repeat (3) rnd_tick();
    fac_loop = 1;
    n0 = loads;
    while (loads == n0) rnd_tick();
    mon_tx = 0; mon_fac = 1; fac_tag = "R4";
    walk_table();

    set_mode(0, 1, 0);
    mon_tx = 1; mon_eq = 1; mon_gap = 1; eq_tag = "R5";
    walk_table();

    set_mode(1, 1, 0);
    mon_fac = 1; mon_eq = 1; fac_tag = "R6"; eq_tag = "R6";
    walk_table();

    set_mode(0, 0, 0);
    mon_tx = 1; mon_rxl = 1;
    repeat (3) rnd_tick();
    loop_time = 1;
    repeat (48) rnd_tick();
    mon_loop = 1; mon_gap = 1; gap_valid = 0; gap = 0;
    walk_table();

    set_mode(0, 0, 0);
    mon_tx = 1; mon_rxl = 1; rxl_tag = "R8";
    los_drive = 0;
    walk_table();
    do tick(1'b1); while (!rx_strobe);
    chk(rx_word == '0, "R8", int'(rx_word), 0);
    set_mode(1, 0, 0);
    for (int k = 0; k < 16; k++) begin
      tick(1'b1);
      chk(line_tx == 1'b0, "R8", int'(line_tx), 0);
    end
    los_drive = 1;

    all_off();
    rst = 1'b1;
    repeat (2) begin
      @(negedge clk);
      chk(!tx_load && !rx_strobe && !line_tx && rx_word == '0, "R9",
          int'({tx_load, rx_strobe, line_tx}), 0);
    end
    rst = 1'b0;
    finish_run();
  end

endmodule